// File: doc/BRIEF.md
# Debiased Random Key Assembler

This block sits behind a noise-source comparator whose output has already been brought into the clock domain. On each sparse sample strobe it takes one raw bit. Raw bits are grouped into back-to-back, non-overlapping pairs. A pair whose two bits differ yields one output bit, equal to the second bit of the pair. A pair whose bits match yields nothing. Because matching pairs are thrown away, the output rate is irregular, and every consumer in the block waits as long as it must.

Debiased bits collect in a one-bit-wide FIFO pool. Software can draw single bits from the pool through a pop port. It can also ask for a complete 64-bit cipher key. The key is built from 56 pool bits, and the block writes an odd-parity bit into the least significant position of each byte. The latest raw comparator level and the pool fill level are also exposed as status.

Top module: `rkey_assembler`

## Requirements
- R1: Raw bits taken on strobes form non-overlapping pairs, starting with the first strobe after reset. The pair (first=0, second=1) yields 1, (1,0) yields 0, and (0,0) and (1,1) yield no bit.
- R2: `raw_status_o` equals the value `raw_bit_i` had at the previous clock edge, whether or not a strobe is present.
- R3: The pool is first-in first-out. `pool_count_o` gives the number of stored bits and `pop_bit_o` shows the oldest bit. When `pop_valid_o` is high, `pop_i` removes that bit.
- R4: A debiased bit that arrives while the pool holds POOL_DEPTH bits is dropped and sets `overflow_o`. The flag stays high until reset.
- R5: `key_req_i` while idle lowers `key_ready_o` on the next cycle and starts assembly. Assembly takes 56 bits from the pool in order. The first bit taken lands in `key_o[63]`. Byte n carries its seven data bits in bits [8n+7:8n+1], most significant byte first.
- R6: Bit 8n of `key_o` makes every byte of a finished key contain an odd number of ones.
- R7: Assembly stalls for as long as the pool is empty. `key_ready_o` rises only in the cycle after the 56th bit is taken.
- R8: While assembling, `pop_valid_o` is low and both `pop_i` and `key_req_i` have no effect. If `key_req_i` and `pop_i` arrive together while idle, the key request wins and no bit is popped.
- R9: After reset, `pool_count_o`, `pop_valid_o`, `overflow_o`, `key_ready_o` and `key_o` are all zero.
- R10: A finished key and `key_ready_o` hold unchanged until the next accepted key request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_bit_i | input | 1 | Synchronised comparator bit |
| raw_stb_i | input | 1 | One-cycle sample strobe |
| raw_status_o | output | 1 | Registered copy of the raw bit |
| pool_count_o | output | $clog2(POOL_DEPTH+1) | Bits held in the pool |
| overflow_o | output | 1 | Sticky flag: a bit was dropped |
| pop_i | input | 1 | Remove the oldest pool bit |
| pop_valid_o | output | 1 | A bit can be popped |
| pop_bit_o | output | 1 | Oldest pool bit |
| key_req_i | input | 1 | Start key assembly |
| key_ready_o | output | 1 | Key complete |
| key_o | output | KEY_BYTES*8 | Assembled key with parity |

## Verification
The bench builds the block with its defaults: a 64-entry pool, which is a power-of-two depth and so selects the natural pointer-wrap variant, and an 8-byte key. With these values, a run of 70 alternating pairs drives the pool past full. This makes the overflow drop and the sticky flag observable, and it leaves exactly 8 bits behind after one key is drawn. The key width makes the parity insertion and the most-significant-byte-first ordering visible on all eight bytes. Biased random streams (about 80 to 85 percent ones) exercise the discard path heavily. A key request made on an empty pool exercises the indefinite stall.

// File: rtl/rkey_pkg.sv
package rkey_pkg;

   typedef enum logic {
      KB_IDLE = 1'b0,
      KB_FILL = 1'b1
   } kb_state_t;

   localparam int unsigned DATA_PER_BYTE = 7;
   localparam int unsigned BITS_PER_BYTE = 8;

   // parity bit that makes 7 data bits plus itself odd
   function automatic logic odd_fill(input logic [DATA_PER_BYTE-1:0] d);
      return ~(^d);
   endfunction

endpackage

// File: rtl/rkey_debias.sv
module rkey_debias (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic stb_i,
   output logic bit_o,
   output logic vld_o
);

   logic half_q;
   logic first_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         half_q  <= 1'b0;
         first_q <= 1'b0;
         vld_o   <= 1'b0;
         bit_o   <= 1'b0;
      end else begin
         vld_o <= 1'b0;
         if (stb_i) begin
            if (!half_q) begin
               first_q <= raw_i;
               half_q  <= 1'b1;
            end else begin
               half_q <= 1'b0;
               if (first_q != raw_i) begin
                  vld_o <= 1'b1;
                  bit_o <= raw_i;
               end
            end
         end
      end
   end

endmodule

// File: rtl/rkey_pool.sv
module rkey_pool #(
   parameter int unsigned DEPTH = 64
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_i,
   input  logic                           wd_i,
   input  logic                           rd_i,
   output logic                           rd_data_o,
   output logic [$clog2(DEPTH+1)-1:0]     count_o,
   output logic                           ovf_o
);

   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH+1);
   localparam bit          POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [DEPTH-1:0] store_q;
   logic [PW-1:0]    wp_q, rp_q, wp_nx, rp_nx;
   logic             full, empty, do_wr, do_rd;

   assign full  = (count_o == CW'(DEPTH));
   assign empty = (count_o == '0);
   assign do_wr = wr_i && !full;
   assign do_rd = rd_i && !empty;
   assign rd_data_o = store_q[rp_q];

   generate
      if (POW2) begin : g_wrap_nat
         assign wp_nx = wp_q + 1'b1;
         assign rp_nx = rp_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
         assign rp_nx = (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         store_q <= '0;
         wp_q    <= '0;
         rp_q    <= '0;
         count_o <= '0;
         ovf_o   <= 1'b0;
      end else begin
         if (do_wr) begin
            store_q[wp_q] <= wd_i;
            wp_q          <= wp_nx;
         end
         if (do_rd) rp_q <= rp_nx;
         if (wr_i && full) ovf_o <= 1'b1;
         case ({do_wr, do_rd})
            2'b10:   count_o <= count_o + 1'b1;
            2'b01:   count_o <= count_o - 1'b1;
            default: count_o <= count_o;
         endcase
      end
   end

endmodule

// File: rtl/rkey_keybuild.sv
module rkey_keybuild
   import rkey_pkg::*;
#(
   parameter int unsigned KEY_BYTES = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_i,
   input  logic                    avail_i,
   input  logic                    bit_i,
   output logic                    take_o,
   output logic                    busy_o,
   output logic [KEY_BYTES*8-1:0]  key_o,
   output logic                    ready_o
);

   localparam int unsigned RAND_W = KEY_BYTES * DATA_PER_BYTE;
   localparam int unsigned KEY_W  = KEY_BYTES * BITS_PER_BYTE;
   localparam int unsigned CW     = $clog2(RAND_W + 1);

   kb_state_t          st_q;
   logic [RAND_W-1:0]  sh_q, sh_nx;
   logic [CW-1:0]      cnt_q;
   logic [KEY_W-1:0]   key_nx;

   assign busy_o = (st_q == KB_FILL);
   assign take_o = busy_o && avail_i;
   assign sh_nx  = {sh_q[RAND_W-2:0], bit_i};

   generate
      for (genvar b = 0; b < KEY_BYTES; b++) begin : g_byte
         assign key_nx[b*8+1 +: 7] = sh_nx[b*7 +: 7];
         assign key_nx[b*8]        = odd_fill(sh_nx[b*7 +: 7]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= KB_IDLE;
         sh_q    <= '0;
         cnt_q   <= '0;
         key_o   <= '0;
         ready_o <= 1'b0;
      end else begin
         case (st_q)
            KB_IDLE: begin
               if (req_i) begin
                  st_q    <= KB_FILL;
                  cnt_q   <= '0;
                  ready_o <= 1'b0;
               end
            end
            KB_FILL: begin
               if (avail_i) begin
                  sh_q  <= sh_nx;
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == CW'(RAND_W - 1)) begin
                     st_q    <= KB_IDLE;
                     key_o   <= key_nx;
                     ready_o <= 1'b1;
                  end
               end
            end
            default: st_q <= KB_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/rkey_assembler.sv
module rkey_assembler #(
   parameter int unsigned POOL_DEPTH = 64,
   parameter int unsigned KEY_BYTES  = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              raw_bit_i,
   input  logic                              raw_stb_i,
   output logic                              raw_status_o,
   output logic [$clog2(POOL_DEPTH+1)-1:0]   pool_count_o,
   output logic                              overflow_o,
   input  logic                              pop_i,
   output logic                              pop_valid_o,
   output logic                              pop_bit_o,
   input  logic                              key_req_i,
   output logic                              key_ready_o,
   output logic [KEY_BYTES*8-1:0]            key_o
);

   localparam int unsigned CNT_W = $clog2(POOL_DEPTH + 1);

   generate
      if (POOL_DEPTH < 2) begin : g_bad_depth
         $error("POOL_DEPTH must be at least 2");
      end
      if (KEY_BYTES < 1 || KEY_BYTES > 16) begin : g_bad_key
         $error("KEY_BYTES must lie in 1..16");
      end
   endgenerate

   logic db_bit, db_vld;
   logic head_bit, take, busy, pop_ok, non_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) raw_status_o <= 1'b0;
      else        raw_status_o <= raw_bit_i;
   end

   rkey_debias u_debias (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw_bit_i),
      .stb_i (raw_stb_i),
      .bit_o (db_bit),
      .vld_o (db_vld)
   );

   assign non_empty   = (pool_count_o != CNT_W'(0));
   assign pop_valid_o = non_empty && !busy;
   assign pop_ok      = pop_i && pop_valid_o && !key_req_i;
   assign pop_bit_o   = head_bit;

   rkey_pool #(.DEPTH(POOL_DEPTH)) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (db_vld),
      .wd_i      (db_bit),
      .rd_i      (take || pop_ok),
      .rd_data_o (head_bit),
      .count_o   (pool_count_o),
      .ovf_o     (overflow_o)
   );

   rkey_keybuild #(.KEY_BYTES(KEY_BYTES)) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (key_req_i),
      .avail_i (non_empty),
      .bit_i   (head_bit),
      .take_o  (take),
      .busy_o  (busy),
      .key_o   (key_o),
      .ready_o (key_ready_o)
   );

endmodule

// File: rtl/rkey_checker.sv
module rkey_checker #(
   parameter int unsigned POOL_DEPTH = 64,
   parameter int unsigned KEY_BYTES  = 8
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              raw_bit_i,
   input logic                              raw_status_o,
   input logic [$clog2(POOL_DEPTH+1)-1:0]   pool_count_o,
   input logic                              overflow_o,
   input logic                              pop_valid_o,
   input logic                              key_req_i,
   input logic                              key_ready_o,
   input logic [KEY_BYTES*8-1:0]            key_o
);

   localparam int unsigned CW = $clog2(POOL_DEPTH + 1);

   logic past_ok;
   logic all_odd;

   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   always_comb begin
      all_odd = 1'b1;
      for (int b = 0; b < KEY_BYTES; b++) all_odd = all_odd & (^key_o[b*8 +: 8]);
   end

   // R2
   raw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> raw_status_o == $past(raw_bit_i));

   // R3
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pool_count_o <= CW'(POOL_DEPTH));

   // R3
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid_o |-> pool_count_o != '0);

   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (({1'b0, pool_count_o}) <= ({1'b0, $past(pool_count_o)} + 1'b1)) &&
                  (({1'b0, pool_count_o} + 1'b1) >= {1'b0, $past(pool_count_o)}));

   // R4
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |=> overflow_o);

   // R5
   req_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_req_i && key_ready_o |=> !key_ready_o);

   // R6
   key_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_ready_o |-> all_odd);

   // R10
   key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_ready_o && !key_req_i |=> key_ready_o && $stable(key_o));

endmodule

bind rkey_assembler rkey_checker #(
   .POOL_DEPTH (POOL_DEPTH),
   .KEY_BYTES  (KEY_BYTES)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .raw_bit_i    (raw_bit_i),
   .raw_status_o (raw_status_o),
   .pool_count_o (pool_count_o),
   .overflow_o   (overflow_o),
   .pop_valid_o  (pop_valid_o),
   .key_req_i    (key_req_i),
   .key_ready_o  (key_ready_o),
   .key_o        (key_o)
);

// File: tb/rkey_assembler_tb.sv
module rkey_assembler_tb_top;

   localparam int unsigned POOL_DEPTH = 64;
   localparam int unsigned KEY_BYTES  = 8;
   localparam int unsigned CNT_W      = $clog2(POOL_DEPTH + 1);
   localparam time         CLK_PERIOD = 10ns;

   logic                    clk = 1'b0;
   logic                    rst_n;
   logic                    raw_bit_i, raw_stb_i, pop_i, key_req_i;
   logic                    raw_status_o, overflow_o, pop_valid_o, pop_bit_o, key_ready_o;
   logic [CNT_W-1:0]        pool_count_o;
   logic [KEY_BYTES*8-1:0]  key_o;

   int unsigned n_run  = 0;
   int unsigned n_fail = 0;
   bit          done   = 0;

   // bench model
   bit          mq[$];
   bit          m_half;
   bit          m_first;
   bit          m_ovf;
   int unsigned m_prod;

   always #(CLK_PERIOD/2) clk = ~clk;

   rkey_assembler #(.POOL_DEPTH(POOL_DEPTH), .KEY_BYTES(KEY_BYTES)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .raw_bit_i    (raw_bit_i),
      .raw_stb_i    (raw_stb_i),
      .raw_status_o (raw_status_o),
      .pool_count_o (pool_count_o),
      .overflow_o   (overflow_o),
      .pop_i        (pop_i),
      .pop_valid_o  (pop_valid_o),
      .pop_bit_o    (pop_bit_o),
      .key_req_i    (key_req_i),
      .key_ready_o  (key_ready_o),
      .key_o        (key_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] key_of(input bit bits[$]);
      logic [63:0] k = '0;
      for (int by = 0; by < KEY_BYTES; by++) begin
         logic [6:0] d;
         for (int j = 0; j < 7; j++) d[6-j] = bits[by*7 + j];
         k[(KEY_BYTES-1-by)*8 +: 8] = {d, ~(^d)};
      end
      return k;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; raw_bit_i = 1'b0; raw_stb_i = 1'b0; pop_i = 1'b0; key_req_i = 1'b0;
      mq.delete(); m_half = 0; m_first = 0; m_ovf = 0; m_prod = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // one strobed raw bit, model updated per the pair rule
   task automatic feed_raw(input bit v);
      raw_bit_i = v; raw_stb_i = 1'b1;
      @(negedge clk);
      raw_stb_i = 1'b0;
      repeat (3) @(negedge clk);
      if (!m_half) begin
         m_first = v; m_half = 1;
      end else begin
         m_half = 0;
         if (m_first != v) begin
            m_prod++;
            if (mq.size() < POOL_DEPTH) mq.push_back(v);
            else m_ovf = 1;
         end
      end
   endtask

   task automatic pop_check(input string req);
      bit e = mq.pop_front();
      check({req, " valid"}, 64'(pop_valid_o), 64'd1);
      check({req, " bit"},   64'(pop_bit_o),   64'(e));
      pop_i = 1'b1;
      @(negedge clk);
      pop_i = 1'b0;
   endtask

   task automatic wait_key(input int unsigned lim);
      for (int i = 0; i < lim && !key_ready_o; i++) @(negedge clk);
   endtask

   task automatic key_from_model(input string req);
      bit kb[$];
      for (int i = 0; i < KEY_BYTES*7; i++) kb.push_back(mq.pop_front());
      check(req, key_o, key_of(kb));
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      do_reset();

      // R9 reset state
      check("R9 count",     64'(pool_count_o), 64'd0);
      check("R9 pop_valid", 64'(pop_valid_o),  64'd0);
      check("R9 overflow",  64'(overflow_o),   64'd0);
      check("R9 ready",     64'(key_ready_o),  64'd0);
      check("R9 key",       key_o,             64'd0);

      // R2 raw status follows without strobe
      raw_bit_i = 1'b1; @(negedge clk);
      check("R2 raw high", 64'(raw_status_o), 64'd1);
      raw_bit_i = 1'b0; @(negedge clk);
      check("R2 raw low", 64'(raw_status_o), 64'd0);
      check("R2 no strobe no bit", 64'(pool_count_o), 64'd0);

      // R1 directed pairs: 00 11 01 10 11 10 01 -> 1 0 0 1
      begin
         bit pat[14] = '{0,0, 1,1, 0,1, 1,0, 1,1, 1,0, 0,1};
         foreach (pat[i]) feed_raw(pat[i]);
      end
      check("R1 pair count", 64'(pool_count_o), 64'd4);
      check("R1 model", 64'({mq[0], mq[1], mq[2], mq[3]}), 64'b1001);
      for (int i = 0; i < 4; i++) pop_check("R1 R3 directed pop");
      check("R3 drained", 64'(pool_count_o), 64'd0);

      // R1 R3 biased random stream
      for (int i = 0; i < 240; i++) feed_raw($urandom_range(99) < 85);
      check("R3 biased count", 64'(pool_count_o), 64'(mq.size()));
      while (mq.size() > 0) pop_check("R1 biased pop");

      // R4 overflow with 70 pairs of 01
      for (int i = 0; i < 70; i++) begin feed_raw(0); feed_raw(1); end
      check("R4 full count", 64'(pool_count_o), 64'(POOL_DEPTH));
      check("R4 overflow",   64'(overflow_o),   64'd1);

      // R5 R6 key from all-ones pool
      key_req_i = 1'b1; @(negedge clk); key_req_i = 1'b0;
      wait_key(400);
      check("R5 R6 all-ones key", key_o, 64'hFEFE_FEFE_FEFE_FEFE);
      check("R5 remaining", 64'(pool_count_o), 64'd8);
      check("R4 still set", 64'(overflow_o), 64'd1);
      for (int i = 0; i < KEY_BYTES*7; i++) void'(mq.pop_front());
      while (mq.size() > 0) pop_check("R3 leftover pop");

      // R10 hold
      repeat (12) @(negedge clk);
      check("R10 ready held", 64'(key_ready_o), 64'd1);
      check("R10 key held",   key_o, 64'hFEFE_FEFE_FEFE_FEFE);

      // R7 R8 starved key build
      do_reset();
      key_req_i = 1'b1; @(negedge clk); key_req_i = 1'b0;
      repeat (20) @(negedge clk);
      check("R7 stalls empty", 64'(key_ready_o), 64'd0);
      check("R8 no pop while busy", 64'(pop_valid_o), 64'd0);
      for (int i = 0; m_prod < 62 && i < 2000; i++) begin
         feed_raw($urandom_range(99) < 80);
         if (i == 40) begin
            pop_i = 1'b1; key_req_i = 1'b1; @(negedge clk);
            pop_i = 1'b0; key_req_i = 1'b0;
         end
      end
      wait_key(400);
      check("R7 ready after 56", 64'(key_ready_o), 64'd1);
      key_from_model("R5 R6 R8 random key");
      check("R7 remaining", 64'(pool_count_o), 64'(mq.size()));
      while (mq.size() > 0) pop_check("R3 post-key pop");

      // R8 key request and pop together: key wins
      for (int i = 0; i < 60; i++) begin feed_raw(1); feed_raw(0); end
      pop_i = 1'b1; key_req_i = 1'b1; @(negedge clk);
      pop_i = 1'b0; key_req_i = 1'b0;
      check("R5 ready drops", 64'(key_ready_o), 64'd0);
      wait_key(400);
      check("R6 all-zero key", key_o, 64'h0101_0101_0101_0101);
      check("R8 pop lost to key", 64'(pool_count_o), 64'd4);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule